// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers interrupt requests from `NSRC` sources and hands a single one to a processor. Every source owns a sticky pending flag, an enable bit and a 3-bit priority. A balanced comparison tree picks the enabled, pending source with the highest priority. Ties go to the lowest source index. The winner is then compared against the processor's current priority level. A request goes to the processor only when the winner is strictly above that level. It carries a vector number, which is the source index plus a fixed base, and a new level equal to the winner's priority.

The processor acknowledges a request, and the level then rises to the presented level. The old level is pushed onto a small stack, and a handler-return strobe pops it back. A nesting-disable control instead forces the level to the top user value on acknowledge, so no further user interrupt can preempt the handler. An external trap-active input forms the fourth, read-only level bit. While it is high, no user request can win.

Software reaches all state through a simple write port and a registered read port. Word addresses: 0 sets flags (ones set), 1 clears flags (ones clear), 2 writes the enable mask, 3 writes the priority of source `reg_idx` from data bits [2:0], 4 writes control (bit 0 global enable, bit 1 nesting disable), 5 writes the level's low three bits. Reads use the same addresses: 0 returns the flags, 2 the enables, 3 the priority of `reg_idx`, 4 the control bits and 5 the 4-bit level with the trap bit in bit 3. Any other address reads 0.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all flags, enables, priorities, control bits and the level are zero, and `irq_req` is low.
- R2: A high `src_irq` bit sets its flag. Only a write of ones to address 0 sets a flag from software, and only a write of ones to address 1 clears one. If a clear and a hardware set hit the same flag in one cycle, the flag stays set.
- R3: A source takes part in arbitration only when its flag is set, its enable bit is set, its priority is non-zero and the global enable (control bit 0) is set.
- R4: Among participating sources, the highest priority wins. On equal priority, the lowest source index wins.
- R5: The presented vector is the winning source index plus `VEC_BASE` (8 by default). The presented level is the winning priority, zero-extended to 4 bits.
- R6: `irq_req` is raised only when the winning level is strictly greater than the current 4-bit level `{trap_active, ipl}`. Bit 3 of the level follows `trap_active` and cannot be written by software.
- R7: When `irq_ack` arrives while `irq_req` is high and nesting is enabled, the level becomes the presented level and the previous level is saved. Each `irq_ret` restores the most recently saved level, which allows nesting.
- R8: With nesting disabled (control bit 1), an acknowledge sets the level's low bits to 7. The following `irq_ret` restores the saved level.
- R9: Outputs are registered. A flag or register change reaches `irq_req`, `irq_vec` and `irq_lvl` on the second clock edge after the input is applied, and `irq_req` is low in the cycle after an accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NSRC | Per-source request pulses that set the flags |
| trap_active | input | 1 | Trap-level bit, forms bit 3 of the level |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | NSRC | Register write data |
| reg_idx | input | IDX_W | Source index for priority writes and reads |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | NSRC | Registered read data |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Latched vector number |
| irq_lvl | output | 4 | Latched new priority level |
| irq_ack | input | 1 | Processor acknowledge |
| irq_ret | input | 1 | Handler return, restores the saved level |

## Verification
The hardest situations to reach are the nested acknowledges and the same-cycle flag clear against a hardware set.

For nesting, the stimulus first acknowledges a lower-priority request and confirms through the level read-back that the level rose. It then raises a higher-priority source, acknowledges that as well, and unwinds with two returns while checking each restored level and the re-presented request.

For the collision, the bench drives a clear write and the source pulse on the same clock edge, then reads the flags back. The trap bit's read-only nature is shown by writing bit 3 and reading the level after the trap input drops.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int REG_AW = 3;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t RA_FSET = 3'd0;
  localparam reg_addr_t RA_FCLR = 3'd1;
  localparam reg_addr_t RA_EN   = 3'd2;
  localparam reg_addr_t RA_PRIO = 3'd3;
  localparam reg_addr_t RA_CTRL = 3'd4;
  localparam reg_addr_t RA_LVL  = 3'd5;

  localparam int CTRL_GIE  = 0;
  localparam int CTRL_NEST = 1;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import prio_irq_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSRC-1:0]          hw_set_i,
  input  logic                     we_i,
  input  reg_addr_t                waddr_i,
  input  logic [NSRC-1:0]          wdata_i,
  input  logic [IDX_W-1:0]         widx_i,
  output logic [NSRC-1:0]          flag_o,
  output logic [NSRC-1:0]          en_o,
  output logic [NSRC*PRIO_W-1:0]   prio_o
);
  logic [NSRC-1:0]        flag_q;
  logic [NSRC-1:0]        en_q;
  logic [NSRC*PRIO_W-1:0] prio_q;
  logic                   wr_fset, wr_fclr, wr_en, wr_prio;

  assign wr_fset = we_i && (waddr_i == RA_FSET);
  assign wr_fclr = we_i && (waddr_i == RA_FCLR);
  assign wr_en   = we_i && (waddr_i == RA_EN);
  assign wr_prio = we_i && (waddr_i == RA_PRIO);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst) begin
          flag_q[i] <= 1'b0;
        end else if (hw_set_i[i] || (wr_fset && wdata_i[i])) begin
          flag_q[i] <= 1'b1;
        end else if (wr_fclr && wdata_i[i]) begin
          flag_q[i] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          prio_q[i*PRIO_W +: PRIO_W] <= '0;
        end else if (wr_prio && (widx_i == IDX_W'(i))) begin
          prio_q[i*PRIO_W +: PRIO_W] <= wdata_i[PRIO_W-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign prio_o = prio_q;

  // R2: a hardware set is never lost, even against a clear
  p_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (hw_set_i != '0) |=> ((flag_q & $past(hw_set_i)) == $past(hw_set_i)));

  // R2: a flag only falls after a software clear write
  p_clear_needs_sw_r2: assert property (@(posedge clk) disable iff (rst)
    (($past(flag_q) & ~flag_q) != '0) |-> $past(we_i && (waddr_i == RA_FCLR)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        req_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [PRIO_W-1:0]      win_prio_o
);
  localparam int LVLS  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int P2    = 1 << LVLS;
  localparam int NODES = 2 * P2 - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  generate
    for (genvar i = 0; i < P2; i++) begin : g_leaf
      if (i < NSRC) begin : g_real
        assign nv[P2-1+i] = req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] != '0);
        assign np[P2-1+i] = prio_i[i*PRIO_W +: PRIO_W];
        assign ni[P2-1+i] = IDX_W'(i);
      end else begin : g_pad
        assign nv[P2-1+i] = 1'b0;
        assign np[P2-1+i] = '0;
        assign ni[P2-1+i] = '0;
      end
    end

    for (genvar n = 0; n < P2 - 1; n++) begin : g_node
      logic take_l;
      assign take_l = nv[2*n+1] && (!nv[2*n+2] || (np[2*n+1] >= np[2*n+2]));
      assign nv[n]  = nv[2*n+1] || nv[2*n+2];
      assign np[n]  = take_l ? np[2*n+1] : np[2*n+2];
      assign ni[n]  = take_l ? ni[2*n+1] : ni[2*n+2];
    end
  endgenerate

  assign any_o      = nv[0];
  assign win_idx_o  = ni[0];
  assign win_prio_o = np[0];

  // R4: no participant beats the winner, and equal priority must sit above it
  always_comb begin
    if (any_o) begin
      for (int j = 0; j < NSRC; j++) begin
        if (req_i[j] && (prio_i[j*PRIO_W +: PRIO_W] != '0)) begin
          p_winner_best_r4: assert ((prio_i[j*PRIO_W +: PRIO_W] < win_prio_o) ||
            ((prio_i[j*PRIO_W +: PRIO_W] == win_prio_o) && (j >= int'(win_idx_o))));
        end
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int PRIO_W = 3,
  parameter int NEST_D = 8,
  parameter int LVL_W  = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we_i,
  input  logic [PRIO_W-1:0] sw_lvl_i,
  input  logic              trap_i,
  input  logic              ack_i,
  input  logic [PRIO_W-1:0] new_lvl_i,
  input  logic              nest_dis_i,
  input  logic              ret_i,
  output logic [LVL_W-1:0]  cur_lvl_o
);
  localparam int PTR_W  = $clog2(NEST_D + 1);
  localparam int SIDX_W = (NEST_D > 1) ? $clog2(NEST_D) : 1;

  logic [PRIO_W-1:0] ipl_q;
  logic [PRIO_W-1:0] stk_q [NEST_D];
  logic [PTR_W-1:0]  sp_q;
  logic              full, empty, push, pop;
  logic [SIDX_W-1:0] push_idx, pop_idx;

  assign full     = (sp_q == PTR_W'(NEST_D));
  assign empty    = (sp_q == '0);
  assign push     = ack_i && !full;
  assign pop      = ret_i && !ack_i && !empty;
  assign push_idx = SIDX_W'(sp_q);
  assign pop_idx  = SIDX_W'(sp_q - PTR_W'(1));

  always_ff @(posedge clk) begin
    if (push) begin
      stk_q[push_idx] <= ipl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl_q <= '0;
      sp_q  <= '0;
    end else if (ack_i) begin
      ipl_q <= nest_dis_i ? {PRIO_W{1'b1}} : new_lvl_i;
      if (push) begin
        sp_q <= sp_q + PTR_W'(1);
      end
    end else if (pop) begin
      ipl_q <= stk_q[pop_idx];
      sp_q  <= sp_q - PTR_W'(1);
    end else if (sw_we_i) begin
      ipl_q <= sw_lvl_i;
    end
  end

  assign cur_lvl_o = {trap_i, ipl_q};

  // R8: nesting disabled forces the top user level
  p_nest_forced_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_i && nest_dis_i) |=> (ipl_q == {PRIO_W{1'b1}}));

  // R7: a return with nothing saved leaves the level alone
  p_ret_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !ack_i && empty && !sw_we_i) |=> $stable(ipl_q));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int PRIO_W   = 3,
  parameter int VEC_BASE = 8,
  parameter int VEC_W    = 8,
  parameter int NEST_D   = 8,
  localparam int IDX_W   = $clog2(NSRC),
  localparam int LVL_W   = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              trap_active,
  input  logic              reg_we,
  input  logic [2:0]        reg_waddr,
  input  logic [NSRC-1:0]   reg_wdata,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [2:0]        reg_raddr,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [LVL_W-1:0]  irq_lvl,
  input  logic              irq_ack,
  input  logic              irq_ret
);
  logic [NSRC-1:0]        flags, enables, part;
  logic [NSRC*PRIO_W-1:0] prios;
  logic                   gie_q, nest_q;
  logic                   any;
  logic [IDX_W-1:0]       win_idx;
  logic [PRIO_W-1:0]      win_prio;
  logic [LVL_W-1:0]       cur_lvl, win_lvl;
  logic                   above, ack_take;
  logic                   irq_req_q;
  logic [VEC_W-1:0]       irq_vec_q;
  logic [LVL_W-1:0]       irq_lvl_q;
  logic [NSRC-1:0]        rdata_q;
  logic                   wr_ctrl, wr_lvl;

  assign wr_ctrl = reg_we && (reg_waddr == RA_CTRL);
  assign wr_lvl  = reg_we && (reg_waddr == RA_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      nest_q <= 1'b0;
    end else if (wr_ctrl) begin
      gie_q  <= reg_wdata[CTRL_GIE];
      nest_q <= reg_wdata[CTRL_NEST];
    end
  end

  irq_flag_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .hw_set_i (src_irq),
    .we_i     (reg_we),
    .waddr_i  (reg_waddr),
    .wdata_i  (reg_wdata),
    .widx_i   (reg_idx),
    .flag_o   (flags),
    .en_o     (enables),
    .prio_o   (prios)
  );

  assign part = flags & enables & {NSRC{gie_q}};

  irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .req_i      (part),
    .prio_i     (prios),
    .any_o      (any),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  assign ack_take = irq_ack && irq_req_q;

  irq_level_ctrl #(.PRIO_W(PRIO_W), .NEST_D(NEST_D), .LVL_W(LVL_W)) u_lvl (
    .clk        (clk),
    .rst        (rst),
    .sw_we_i    (wr_lvl),
    .sw_lvl_i   (reg_wdata[PRIO_W-1:0]),
    .trap_i     (trap_active),
    .ack_i      (ack_take),
    .new_lvl_i  (irq_lvl_q[PRIO_W-1:0]),
    .nest_dis_i (nest_q),
    .ret_i      (irq_ret),
    .cur_lvl_o  (cur_lvl)
  );

  assign win_lvl = {1'b0, win_prio};
  assign above   = any && (win_lvl > cur_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req_q <= 1'b0;
      irq_vec_q <= '0;
      irq_lvl_q <= '0;
    end else begin
      irq_req_q <= above && !ack_take;
      if (above) begin
        irq_vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        irq_lvl_q <= win_lvl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_raddr)
        RA_FSET: rdata_q <= flags;
        RA_EN:   rdata_q <= enables;
        RA_PRIO: rdata_q <= NSRC'(prios[int'(reg_idx)*PRIO_W +: PRIO_W]);
        RA_CTRL: rdata_q <= NSRC'({nest_q, gie_q});
        RA_LVL:  rdata_q <= NSRC'(cur_lvl);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign irq_req   = irq_req_q;
  assign irq_vec   = irq_vec_q;
  assign irq_lvl   = irq_lvl_q;
  assign reg_rdata = rdata_q;

  // R6: a presented request was above the level it was compared with
  p_req_above_r6: assert property (@(posedge clk) disable iff (rst)
    irq_req_q |-> (irq_lvl_q > $past(cur_lvl)));

  // R5: vectors stay inside the mapped window
  p_vec_range_r5: assert property (@(posedge clk) disable iff (rst)
    irq_req_q |-> ((irq_vec_q >= VEC_W'(VEC_BASE)) &&
                   (irq_vec_q < VEC_W'(VEC_BASE + NSRC))));

  // R9: an accepted acknowledge drops the request for one cycle
  p_drop_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> !irq_req_q);

  // R7: with nesting on, the level takes the presented level
  p_ack_level_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !nest_q) |=> (cur_lvl[PRIO_W-1:0] == $past(irq_lvl_q[PRIO_W-1:0])));

  // R3: global enable off means no request after one cycle
  p_gie_off_r3: assert property (@(posedge clk) disable iff (rst)
    !gie_q |=> !irq_req_q);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NSRC  = 16;
  localparam int IDX_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSRC-1:0]   src_irq = '0;
  logic              trap_active = 1'b0;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_waddr = '0;
  logic [NSRC-1:0]   reg_wdata = '0;
  logic [IDX_W-1:0]  reg_idx = '0;
  logic [2:0]        reg_raddr = '0;
  logic [NSRC-1:0]   reg_rdata;
  logic              irq_req;
  logic [7:0]        irq_vec;
  logic [3:0]        irq_lvl;
  logic              irq_ack = 1'b0;
  logic              irq_ret = 1'b0;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  typedef struct {
    int    due;
    bit    req;
    int    vec;
    int    lvl;
    string tag;
  } exp_t;
  exp_t sb [$];
  exp_t cur;

  always #4 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .src_irq(src_irq), .trap_active(trap_active),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_idx(reg_idx), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expectations whose cycle has come
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      cur = sb.pop_front();
      total++;
      if ((irq_req !== cur.req) ||
          (cur.req && ((int'(irq_vec) != cur.vec) || (int'(irq_lvl) != cur.lvl)))) begin
        bad++;
        $display("FAIL %s: req/vec/lvl got %0d/%0d/%0d exp %0d/%0d/%0d",
                 cur.tag, irq_req, irq_vec, irq_lvl, cur.req, cur.vec, cur.lvl);
      end
    end
  end

  task automatic expect_out(input bit req, input int vec, input int lvl, input string tag);
    sb.push_back('{cyc + 1, req, vec, lvl, tag});
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NSRC-1:0] d, input int idx);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d; reg_idx = IDX_W'(idx);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk); src_irq = m;
    @(negedge clk); src_irq = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int idx, input int exp, input string tag);
    @(negedge clk); reg_raddr = a; reg_idx = IDX_W'(idx);
    @(negedge clk);
    total++;
    if (int'(reg_rdata) != exp) begin
      bad++;
      $display("FAIL %s: read got 0x%0h exp 0x%0h", tag, reg_rdata, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung exp done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_out(1'b0, 0, 0, "R1 no request");
    rd_chk(3'd0, 0, 0, "R1 flags");
    rd_chk(3'd2, 0, 0, "R1 enables");
    rd_chk(3'd3, 3, 0, "R1 priority");
    rd_chk(3'd4, 0, 0, "R1 control");
    rd_chk(3'd5, 0, 0, "R1 level");

    wr(3'd4, 16'h0001, 0);
    wr(3'd3, 16'd4, 3);
    wr(3'd3, 16'd4, 5);
    wr(3'd3, 16'd6, 10);
    wr(3'd3, 16'd0, 1);
    wr(3'd3, 16'd7, 12);
    wr(3'd2, 16'h042A, 0);
    rd_chk(3'd3, 10, 6, "R3 priority readback");

    // R9 latency, R5 vector mapping
    pulse(16'h0020);
    total++;
    if (irq_req !== 1'b0) begin
      bad++;
      $display("FAIL R9 early output: got %0d exp 0", irq_req);
    end
    expect_out(1'b1, 13, 4, "R5 single source 5");
    pulse(16'h0008);
    expect_out(1'b1, 11, 4, "R4 tie lowest index");
    pulse(16'h0400);
    expect_out(1'b1, 18, 6, "R4 highest priority");
    pulse(16'h1000);
    expect_out(1'b1, 18, 6, "R3 disabled source ignored");
    rd_chk(3'd0, 0, 16'h1428, "R2 hardware set");
    pulse(16'h0002);
    expect_out(1'b1, 18, 6, "R3 priority zero ignored");
    wr(3'd1, 16'h0400, 0);
    expect_out(1'b1, 11, 4, "R2 software clear");
    rd_chk(3'd0, 0, 16'h102A, "R2 flags after clear");

    // R6 level comparison and trap bit
    wr(3'd5, 16'd4, 0);
    expect_out(1'b0, 0, 0, "R6 equal level blocks");
    rd_chk(3'd5, 0, 4, "R6 level write");
    wr(3'd5, 16'd3, 0);
    expect_out(1'b1, 11, 4, "R6 above level");
    @(negedge clk); trap_active = 1'b1;
    expect_out(1'b0, 0, 0, "R6 trap blocks");
    rd_chk(3'd5, 0, 11, "R6 trap bit read");
    @(negedge clk); trap_active = 1'b0;
    wr(3'd5, 16'h0008, 0);
    rd_chk(3'd5, 0, 0, "R6 bit3 read only");
    expect_out(1'b1, 11, 4, "R6 request after trap");

    // R7 nesting
    do_ack();
    total++;
    if (irq_req !== 1'b0) begin
      bad++;
      $display("FAIL R9 drop after ack: got %0d exp 0", irq_req);
    end
    expect_out(1'b0, 0, 0, "R7 masked after ack");
    rd_chk(3'd5, 0, 4, "R7 level raised");
    pulse(16'h0400);
    expect_out(1'b1, 18, 6, "R7 nested request");
    do_ack();
    rd_chk(3'd5, 0, 6, "R7 nested level");
    expect_out(1'b0, 0, 0, "R7 nothing above 6");
    do_ret();
    rd_chk(3'd5, 0, 4, "R7 first return");
    do_ret();
    rd_chk(3'd5, 0, 0, "R7 second return");
    expect_out(1'b1, 18, 6, "R7 request after returns");

    // R8 nesting disabled
    wr(3'd4, 16'h0003, 0);
    do_ack();
    rd_chk(3'd5, 0, 7, "R8 level forced");
    wr(3'd1, 16'h0400, 0);
    expect_out(1'b0, 0, 0, "R8 no nesting");
    do_ret();
    rd_chk(3'd5, 0, 0, "R8 level restored");
    expect_out(1'b1, 11, 4, "R8 resume");

    // R2 collision: clear and set on one edge
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 3'd1; reg_wdata = 16'h0020; src_irq = 16'h0020;
    @(negedge clk);
    reg_we = 1'b0; src_irq = '0;
    rd_chk(3'd0, 0, 16'h102A, "R2 set wins");
    wr(3'd1, 16'h0028, 0);
    expect_out(1'b0, 0, 0, "R2 cleared sources gone");

    // R3 global enable
    pulse(16'h0008);
    expect_out(1'b1, 11, 4, "R3 enabled again");
    wr(3'd4, 16'h0000, 0);
    expect_out(1'b0, 0, 0, "R3 global enable off");
    wr(3'd0, 16'h0020, 0);
    rd_chk(3'd0, 0, 16'h102A, "R2 software set");
    expect_out(1'b0, 0, 0, "R3 still gated");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule